// File: doc/BRIEF.md
# DDR3 Bank Command Timing Gate

This block stands between a memory request scheduler and a DDR3 command bus. The scheduler offers one command at a time: ACTIVATE, READ, WRITE or PRECHARGE, with a bank index. The block holds that command back until the addressed bank's timers have run out and the command-rate gate is open. It then accepts the command, and in the next cycle it drives the command onto its issue outputs. After a READ it raises a one-cycle read-data strobe once the CAS latency has passed. After a WRITE it raises a write-data strobe once the CAS write latency has passed.

Each of the eight banks keeps an open/closed flag and two down-counters. One counter holds off column commands after an activation. The other holds off a new activation after a precharge. A configuration input selects one of three speed presets. Two more inputs choose the command rate: one command per clock, or one every two clocks. When two modules share the channel, the block always uses one command every two clocks.

The request side is a valid/ready handshake. A command transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on the state of the offered bank and on the rate gate, so the scheduler may change its offer while `req_ready` is low. Only a transferred command has any effect. An ACTIVATE to a bank that is already open, or a READ or WRITE to a bank that is closed, still transfers, but it issues nothing and raises `illegal` instead. The configuration inputs are expected to stay stable while commands or data strobes are still pending.

Top module: `cmd_timing_gate`

## Requirements
- R1: A synchronous active-high reset closes all banks and clears all timers. In the cycle after reset, the issue outputs, `illegal` and both data strobes are low, and an ACTIVATE to any bank is accepted at once and issued as legal.
- R2: Command codes on `req_cmd` and `iss_cmd` are 0 = ACTIVATE, 1 = READ, 2 = WRITE, 3 = PRECHARGE. The `cfg_bin` presets give CAS latency / activate-to-column delay / precharge period / CAS write latency in clocks: 0 gives 7/7/7/6, 1 gives 8/8/8/6, and 2 or 3 give 9/9/9/7.
- R3: A command transferred at edge k appears on `iss_valid`, `iss_cmd` and `iss_bank` for exactly the cycle after edge k.
- R4: Any command to a bank activated at edge k is accepted no earlier than edge k + tRCD.
- R5: Any command to a bank precharged at edge k is accepted no earlier than edge k + tRP. A PRECHARGE to a closed bank is legal and restarts that wait.
- R6: Each bank's timers and state are independent. A command to another bank is not held by them.
- R7: In one-per-clock mode, with timers clear, commands are accepted on consecutive edges.
- R8: In two-clock mode (`cfg_cmd_2n` high, or `cfg_two_dimm` high whatever `cfg_cmd_2n` is), `req_ready` is low in the cycle after each transfer.
- R9: A transferred ACTIVATE to an open bank, or READ/WRITE to a closed bank, issues nothing, leaves the bank unchanged and pulses `illegal` in the next cycle.
- R10: `rd_data_valid` pulses for one cycle, tCL cycles after the READ's issue cycle.
- R11: `wr_data_valid` pulses for one cycle, CWL cycles after the WRITE's issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bin | input | 2 | Speed preset select |
| cfg_cmd_2n | input | 1 | Request one command every two clocks |
| cfg_two_dimm | input | 1 | Two modules per channel; forces two-clock rate |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Offered command may transfer this edge |
| req_cmd | input | 2 | Offered command code |
| req_bank | input | 3 | Offered bank index |
| iss_valid | output | 1 | Command issued this cycle |
| iss_cmd | output | 2 | Issued command code |
| iss_bank | output | 3 | Issued bank index |
| illegal | output | 1 | Transferred command was rejected |
| rd_data_valid | output | 1 | Read data valid strobe |
| wr_data_valid | output | 1 | Write data expected strobe |

## Verification
Some properties are checked on every cycle: the quiet state after reset, that issue outputs only follow a transfer and echo it, that a cycle never carries both an issue and a reject, the dead cycle after each transfer in two-clock mode, and the strobe latency of one read preset and one write preset. The bench covers what needs per-bank history. It keeps a reference model of bank state and the edge numbers of each ACTIVATE, PRECHARGE and transfer. From that model it predicts `req_ready` every cycle, across all presets and both rate modes, including the forced two-clock case. It also covers holds on recently activated or precharged banks, rejects, and the closing of banks by reset.

// File: rtl/cmdt_pkg.sv
package cmdt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } ddr_cmd_e;

  localparam int TW = 4;

  typedef struct packed {
    logic [TW-1:0] cl;
    logic [TW-1:0] rcd;
    logic [TW-1:0] rp;
    logic [TW-1:0] cwl;
  } speed_t;

  function automatic speed_t speed_preset(input logic [1:0] bin);
    speed_t s;
    case (bin)
      2'd0:    s = '{cl: 4'd7, rcd: 4'd7, rp: 4'd7, cwl: 4'd6};
      2'd1:    s = '{cl: 4'd8, rcd: 4'd8, rp: 4'd8, cwl: 4'd6};
      default: s = '{cl: 4'd9, rcd: 4'd9, rp: 4'd9, cwl: 4'd7};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bank_timers.sv
module bank_timers #(
  parameter int NBANK = 8,
  parameter int TW    = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_act,
  input  logic             ld_pre,
  input  logic [BW-1:0]    ld_bank,
  input  logic [TW-1:0]    rcd_init,
  input  logic [TW-1:0]    rp_init,
  output logic [NBANK-1:0] busy,
  output logic [NBANK-1:0] is_open
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [TW-1:0] rcd_q;
    logic [TW-1:0] rp_q;
    logic          open_q;
    logic          hit;

    assign hit = (ld_bank == BW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        rcd_q  <= '0;
        rp_q   <= '0;
        open_q <= 1'b0;
      end else begin
        if (hit && ld_act) begin
          rcd_q  <= rcd_init;
          open_q <= 1'b1;
        end else if (rcd_q != '0) begin
          rcd_q <= rcd_q - 1'b1;
        end
        if (hit && ld_pre) begin
          rp_q   <= rp_init;
          open_q <= 1'b0;
        end else if (rp_q != '0) begin
          rp_q <= rp_q - 1'b1;
        end
      end
    end

    assign busy[g]    = (rcd_q != '0) || (rp_q != '0);
    assign is_open[g] = open_q;
  end

endmodule

// File: rtl/rate_gate.sv
module rate_gate (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic two_n,
  output logic open_o
);

  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= fire && two_n;
  end

  assign open_o = !hold_q;

endmodule

// File: rtl/lat_pipe.sv
module lat_pipe #(
  parameter int DEPTH = 16,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] lat,
  output logic          pulse
);

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] inject;

  assign inject = push ? (DEPTH'(1) << lat) : '0;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= (pipe_q >> 1) | inject;
  end

  assign pulse = pipe_q[0];

endmodule

// File: rtl/cmd_timing_gate.sv
module cmd_timing_gate
  import cmdt_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int PIPE  = 16,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_bin,
  input  logic          cfg_cmd_2n,
  input  logic          cfg_two_dimm,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  output logic          iss_valid,
  output logic [1:0]    iss_cmd,
  output logic [BW-1:0] iss_bank,
  output logic          illegal,
  output logic          rd_data_valid,
  output logic          wr_data_valid
);

  speed_t           spd;
  ddr_cmd_e         cmd;
  logic             two_n;
  logic             gate_open;
  logic [NBANK-1:0] busy;
  logic [NBANK-1:0] is_open;
  logic             legal;
  logic             fire;
  logic             go;

  assign spd   = speed_preset(cfg_bin);
  assign cmd   = ddr_cmd_e'(req_cmd);
  assign two_n = cfg_cmd_2n || cfg_two_dimm;

  always_comb begin
    case (cmd)
      CMD_ACT: legal = !is_open[req_bank];
      CMD_RD,
      CMD_WR:  legal = is_open[req_bank];
      default: legal = 1'b1;
    endcase
  end

  assign req_ready = gate_open && !busy[req_bank];
  assign fire      = req_valid && req_ready;
  assign go        = fire && legal;

  bank_timers #(.NBANK(NBANK), .TW(TW)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .ld_act   (go && cmd == CMD_ACT),
    .ld_pre   (go && cmd == CMD_PRE),
    .ld_bank  (req_bank),
    .rcd_init (TW'(spd.rcd - 1'b1)),
    .rp_init  (TW'(spd.rp - 1'b1)),
    .busy     (busy),
    .is_open  (is_open)
  );

  rate_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .two_n  (two_n),
    .open_o (gate_open)
  );

  lat_pipe #(.DEPTH(PIPE), .TW(TW)) u_rd_pipe (
    .clk   (clk),
    .rst   (rst),
    .push  (go && cmd == CMD_RD),
    .lat   (spd.cl),
    .pulse (rd_data_valid)
  );

  lat_pipe #(.DEPTH(PIPE), .TW(TW)) u_wr_pipe (
    .clk   (clk),
    .rst   (rst),
    .push  (go && cmd == CMD_WR),
    .lat   (spd.cwl),
    .pulse (wr_data_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_cmd   <= 2'd0;
      iss_bank  <= '0;
      illegal   <= 1'b0;
    end else begin
      iss_valid <= go;
      illegal   <= fire && !legal;
      if (go) begin
        iss_cmd  <= req_cmd;
        iss_bank <= req_bank;
      end
    end
  end

endmodule

// File: rtl/cmd_timing_chk.sv
module cmd_timing_chk #(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_bin,
  input logic          cfg_cmd_2n,
  input logic          cfg_two_dimm,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic          iss_valid,
  input logic [1:0]    iss_cmd,
  input logic [BW-1:0] iss_bank,
  input logic          illegal,
  input logic          rd_data_valid,
  input logic          wr_data_valid
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!iss_valid && !illegal && !rd_data_valid && !wr_data_valid));

  a_r3_issue_echoes_transfer: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> ($past(req_valid && req_ready) && iss_cmd == $past(req_cmd)
                   && iss_bank == $past(req_bank)));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && illegal));

  a_r8_two_n_gap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (cfg_cmd_2n || cfg_two_dimm)) |=> !req_ready);

  a_r10_read_cl7: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_cmd == 2'd1 && cfg_bin == 2'd0) |-> ##7 rd_data_valid);

  a_r11_write_cwl7: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_cmd == 2'd2 && cfg_bin == 2'd2) |-> ##7 wr_data_valid);

endmodule

bind cmd_timing_gate cmd_timing_chk #(.BW(BW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_bin       (cfg_bin),
  .cfg_cmd_2n    (cfg_cmd_2n),
  .cfg_two_dimm  (cfg_two_dimm),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_cmd       (req_cmd),
  .req_bank      (req_bank),
  .iss_valid     (iss_valid),
  .iss_cmd       (iss_cmd),
  .iss_bank      (iss_bank),
  .illegal       (illegal),
  .rd_data_valid (rd_data_valid),
  .wr_data_valid (wr_data_valid)
);

// File: tb/tb_cmd_timing_gate.sv
module tb_cmd_timing_gate;

  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_bin = 2'd0;
  logic       cfg_cmd_2n = 1'b0;
  logic       cfg_two_dimm = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_cmd = 2'd0;
  logic [2:0] req_bank = 3'd0;
  logic       iss_valid;
  logic [1:0] iss_cmd;
  logic [2:0] iss_bank;
  logic       illegal;
  logic       rd_data_valid;
  logic       wr_data_valid;

  always #5 clk = ~clk;

  cmd_timing_gate dut (
    .clk(clk), .rst(rst), .cfg_bin(cfg_bin), .cfg_cmd_2n(cfg_cmd_2n),
    .cfg_two_dimm(cfg_two_dimm), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_bank(req_bank), .iss_valid(iss_valid),
    .iss_cmd(iss_cmd), .iss_bank(iss_bank), .illegal(illegal),
    .rd_data_valid(rd_data_valid), .wr_data_valid(wr_data_valid)
  );

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  always @(posedge clk) n <= n + 1;

  // reference model
  bit   mopen [NB];
  int   act_e [NB];
  int   pre_e [NB];
  int   last_e;
  bit   e_iss [64];
  bit   e_ill [64];
  bit   e_rd  [64];
  bit   e_wr  [64];
  int   e_cmd [64];
  int   e_bank[64];
  bit   took;

  // R2 presets
  function automatic int f_cl(input logic [1:0] b);
    return (b == 2'd0) ? 7 : (b == 2'd1) ? 8 : 9;
  endfunction
  function automatic int f_cwl(input logic [1:0] b);
    return (b == 2'd2 || b == 2'd3) ? 7 : 6;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d edge=%0d", tag, act, exp, n);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      mopen[b] = 1'b0; act_e[b] = -1000; pre_e[b] = -1000;
    end
    last_e = -1000;
    for (int s = 0; s < 64; s++) begin
      e_iss[s] = 0; e_ill[s] = 0; e_rd[s] = 0; e_wr[s] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic step(input bit v, input int cmd, input int bank);
    int  slot, e, lat_rcd, lat_rp;
    bit  two, exp_rdy, legal;
    @(negedge clk);
    slot = n % 64;
    chk(iss_valid == e_iss[slot], "R3 iss_valid", int'(iss_valid), int'(e_iss[slot]));
    if (e_iss[slot]) begin
      chk(int'(iss_cmd) == e_cmd[slot], "R2 R3 iss_cmd", int'(iss_cmd), e_cmd[slot]);
      chk(int'(iss_bank) == e_bank[slot], "R3 iss_bank", int'(iss_bank), e_bank[slot]);
    end
    chk(illegal == e_ill[slot], "R9 illegal", int'(illegal), int'(e_ill[slot]));
    chk(rd_data_valid == e_rd[slot], "R10 rd_data_valid", int'(rd_data_valid), int'(e_rd[slot]));
    chk(wr_data_valid == e_wr[slot], "R11 wr_data_valid", int'(wr_data_valid), int'(e_wr[slot]));
    e_iss[slot] = 0; e_ill[slot] = 0; e_rd[slot] = 0; e_wr[slot] = 0;
    req_valid = v; req_cmd = 2'(cmd); req_bank = 3'(bank);
    #1;
    e       = n + 1;
    lat_rcd = f_cl(cfg_bin);
    lat_rp  = f_cl(cfg_bin);
    two     = cfg_cmd_2n || cfg_two_dimm;
    exp_rdy = (e - act_e[bank] >= lat_rcd) && (e - pre_e[bank] >= lat_rp)
              && (!two || (e - last_e >= 2));
    chk(req_ready == exp_rdy, "R4 R5 R6 R7 R8 req_ready", int'(req_ready), int'(exp_rdy));
    took = v && req_ready;
    if (took) begin
      last_e = e;
      legal = (cmd == 3) || ((cmd == 0) ? !mopen[bank] : mopen[bank]);
      if (legal) begin
        e_iss[e % 64] = 1; e_cmd[e % 64] = cmd; e_bank[e % 64] = bank;
        case (cmd)
          0: begin mopen[bank] = 1'b1; act_e[bank] = e; end
          1: e_rd[(e + f_cl(cfg_bin)) % 64] = 1;
          2: e_wr[(e + f_cwl(cfg_bin)) % 64] = 1;
          default: begin mopen[bank] = 1'b0; pre_e[bank] = e; end
        endcase
      end else begin
        e_ill[e % 64] = 1;
      end
    end
  endtask

  task automatic send(input int cmd, input int bank);
    for (int i = 0; i < 40; i++) begin
      step(1'b1, cmd, bank);
      if (took) break;
    end
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) step(1'b0, 0, 0);
  endtask

  task automatic random_run(input int cyc);
    bit hold_req = 0;
    int cmd = 0, bank = 0;
    for (int i = 0; i < cyc; i++) begin
      if (!hold_req) begin
        int r;
        r    = $urandom % 100;
        bank = $urandom % NB;
        if (r < 12)                cmd = $urandom % 4;
        else if (mopen[bank])      cmd = (r < 45) ? 1 : (r < 80) ? 2 : 3;
        else                       cmd = 0;
        hold_req = ($urandom % 100) < 80;
      end
      step(hold_req, cmd, bank);
      if (took) hold_req = 0;
    end
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    model_reset();
    do_reset();

    // R1: quiet after reset, ACTIVATE accepted at once
    @(negedge clk);
    chk(!iss_valid && !illegal && !rd_data_valid && !wr_data_valid,
        "R1 outputs after reset", int'(iss_valid), 0);
    for (int ph = 0; ph < 4; ph++) begin
      cfg_bin      = 2'(ph);
      cfg_cmd_2n   = (ph == 1);
      cfg_two_dimm = (ph == 2);
      idle(12);
      // R4: column command held after activation; R6: other bank free
      send(0, 0);
      send(1, 0);
      send(0, 1);
      send(2, 1);
      // R7/R8: back-to-back activations on distinct banks
      send(0, 2);
      send(0, 3);
      // R9: reads/writes to closed bank, activate to open bank
      send(1, 5);
      send(2, 6);
      send(0, 0);
      // R5: precharge then reactivate waits tRP; precharge of closed bank
      send(3, 0);
      send(0, 0);
      send(3, 7);
      send(0, 7);
      idle(12);
      random_run(600);
      idle(14);
    end

    // R1: reset closes open banks; ACTIVATE to a formerly open bank is legal
    cfg_bin = 2'd0; cfg_cmd_2n = 1'b0; cfg_two_dimm = 1'b0;
    send(3, 4);
    idle(10);
    send(0, 4);
    idle(2);
    do_reset();
    send(0, 4);
    idle(3);
    chk(mopen[4] == 1'b1, "R1 reactivation after reset legal", int'(mopen[4]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", n, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule